// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block connects a synchronous host port to an external asynchronous static RAM. The RAM holds 32K words of 8 bits. The host raises a request with a read/write select, a 15-bit word address and write data. The block then drives the RAM's active-low chip select, write strobe and output strobe. It also drives the address and a split data bus (outgoing data, incoming data and a drive enable). Each access runs through a fixed phase sequence. When the access completes, the block returns a single-cycle completion pulse. On a read, the captured byte is valid at the same time as that pulse.

The RAM's timing figures are given as picosecond parameters together with the clock period. Each figure is rounded up to whole clock cycles, with a minimum of one cycle. The figures are: address setup, write strobe width, data setup, address-to-write-end, data hold, access time, output-enable access and output float time. With the defaults (4 ns clock), the phase lengths are:

- setup: 1 cycle
- write strobe: 2 cycles
- read strobe: 2 cycles
- write hold: 1 cycle
- read turnaround: 2 cycles

Between accesses the RAM is deselected, so it rests in its low-power standby state. The block only drives the data bus while the RAM's outputs are known to be floating.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it, sram_ce_no, sram_we_no and sram_oe_no are 1, sram_dq_oe_o is 0, done_o is 0 and ready_o is 1.
- R2: Whenever ready_o is 1 (no access in progress), chip select, write strobe and output strobe are all high and sram_dq_oe_o is 0.
- R3: A write drives sram_we_no low for exactly WR_C consecutive cycles (2 by default). The low window is preceded by SETUP_C cycles (1 by default) with chip select low and the strobe high. sram_dq_oe_o is 1 throughout the low window, and the word lands at the latched address.
- R4: After the write strobe rises, address and data stay driven with sram_dq_oe_o at 1 for exactly HD_C cycles (1 by default). Then the bus is released.
- R5: A read holds sram_oe_no low for exactly RD_C cycles (2 by default) with sram_we_no high. rdata_o takes the sram_dq_i value present on the last of those cycles.
- R6: sram_dq_oe_o never rises sooner than TA_C cycles (2 by default) after sram_oe_no rose.
- R7: sram_dq_oe_o is never 1 while sram_oe_no is 0. The write and output strobes are never both low.
- R8: done_o is a one-cycle pulse, with exactly one pulse per accepted request. The pulse arrives SETUP_C+WR_C+HD_C+1 cycles after acceptance for a write (5 by default) and SETUP_C+RD_C+TA_C+1 cycles for a read (6 by default).
- R9: ready_o is 0 from the acceptance edge until after done_o. Request, select, address and data changes during that time are ignored and start no access.
- R10: sram_addr_o is stable for the whole time chip select is low. Chip select returns high in the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, accepted when ready_o is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Idle, a request is accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| sram_ce_no | output | 1 | RAM chip select, active low |
| sram_we_no | output | 1 | RAM write strobe, active low |
| sram_oe_no | output | 1 | RAM output strobe, active low |
| sram_addr_o | output | 15 | RAM address |
| sram_dq_o | output | 8 | Data toward the RAM |
| sram_dq_i | input | 8 | Data from the RAM |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |

## Verification
The hardest case to reach is a read immediately followed by a write. In that case the controller's bus drive must wait out the RAM's output float time. Getting there needs a request waiting at the exact cycle the controller returns to idle. The stimulus therefore chains read-then-write pairs with no gap, and runs an address stream with the request held high throughout. The bench's RAM model presents valid read data only in the final cycle of the output window, so a capture taken too early returns a junk byte. A second hard case is a request held across a busy access while its address and select change. The bench checks this by reading both addresses back afterwards.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } phase_e;

  // whole clock cycles covering t_ps, never below floor_c
  function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps,
                                            int unsigned floor_c);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < floor_c) ? floor_c : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // remaining cycles after a, at least one
  function automatic int unsigned rem_u(int unsigned total, int unsigned a);
    return (total > a) ? total - a : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned SETUP_C = 1,
  parameter int unsigned WR_C    = 2,
  parameter int unsigned RD_C    = 2,
  parameter int unsigned HD_C    = 1,
  parameter int unsigned TA_C    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             op_we_i,
  input  logic             expired_i,
  output phase_e           state_q_o,
  output phase_e           state_d_o,
  output logic             accept_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  localparam logic [CNT_W-1:0] SETUP_V = CNT_W'(SETUP_C - 1);
  localparam logic [CNT_W-1:0] WR_V    = CNT_W'(WR_C - 1);
  localparam logic [CNT_W-1:0] RD_V    = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] HD_V    = CNT_W'(HD_C - 1);
  localparam logic [CNT_W-1:0] TA_V    = CNT_W'(TA_C - 1);

  phase_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        state_d    = ST_SETUP;
        load_o     = 1'b1;
        load_val_o = SETUP_V;
      end
      ST_SETUP: if (expired_i) begin
        state_d    = ST_STROBE;
        load_o     = 1'b1;
        load_val_o = op_we_i ? WR_V : RD_V;
      end
      ST_STROBE: if (expired_i) begin
        state_d    = ST_HOLD;
        load_o     = 1'b1;
        load_val_o = op_we_i ? HD_V : TA_V;
      end
      ST_HOLD: if (expired_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  phase_e            state_q_i,
  input  phase_e            state_d_i,
  input  logic              expired_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              op_we_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              op_we_q;
  logic              ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              busy_d, we_act_d, oe_act_d, drv_d, cap;

  // pins are registered from the next phase: glitch-free, aligned with state_q
  always_comb begin
    busy_d   = (state_d_i == ST_SETUP) || (state_d_i == ST_STROBE) || (state_d_i == ST_HOLD);
    we_act_d = (state_d_i == ST_STROBE) && op_we_q;
    oe_act_d = (state_d_i == ST_STROBE) && !op_we_q;
    drv_d    = op_we_q && ((state_d_i == ST_STROBE) || (state_d_i == ST_HOLD));
    cap      = (state_q_i == ST_STROBE) && !op_we_q && expired_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_q <= 1'b0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ce_n_q  <= !busy_d;
      we_n_q  <= !we_act_d;
      oe_n_q  <= !oe_act_d;
      dq_oe_q <= drv_d;
      if (accept_i) begin
        op_we_q <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (cap) rdata_q <= dq_i;
    end
  end

  assign op_we_o = op_we_q;
  assign ce_n_o  = ce_n_q;
  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign dq_oe_o = dq_oe_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_ASU_PS  = 0,
  parameter int unsigned T_PWE_PS  = 7000,
  parameter int unsigned T_SD_PS   = 5000,
  parameter int unsigned T_AW_PS   = 7000,
  parameter int unsigned T_HD_PS   = 0,
  parameter int unsigned T_AA_PS   = 10000,
  parameter int unsigned T_DOE_PS  = 5000,
  parameter int unsigned T_HZOE_PS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);

  localparam int unsigned SETUP_C = ps_to_cyc(T_ASU_PS, CLK_PS, 1);
  localparam int unsigned WR_C    = max_u(max_u(ps_to_cyc(T_PWE_PS, CLK_PS, 1),
                                                ps_to_cyc(T_SD_PS, CLK_PS, 1)),
                                          rem_u(ps_to_cyc(T_AW_PS, CLK_PS, 1), SETUP_C));
  localparam int unsigned RD_C    = max_u(ps_to_cyc(T_DOE_PS, CLK_PS, 1),
                                          rem_u(ps_to_cyc(T_AA_PS, CLK_PS, 1), SETUP_C));
  localparam int unsigned HD_C    = ps_to_cyc(T_HD_PS, CLK_PS, 1);
  localparam int unsigned TA_C    = ps_to_cyc(T_HZOE_PS, CLK_PS, 1);
  localparam int unsigned MAX_C   = max_u(max_u(SETUP_C, WR_C), max_u(max_u(RD_C, HD_C), TA_C));
  localparam int unsigned CNT_W   = $clog2(MAX_C + 1);

  phase_e           state_q, state_d;
  logic             accept, load, expired, op_we;
  logic [CNT_W-1:0] load_val;

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .SETUP_C(SETUP_C), .WR_C(WR_C), .RD_C(RD_C), .HD_C(HD_C), .TA_C(TA_C)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_we_i    (op_we),
    .expired_i  (expired),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .accept_o   (accept),
    .load_o     (load),
    .load_val_o (load_val)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .state_q_i (state_q),
    .state_d_i (state_d),
    .expired_i (expired),
    .dq_i      (sram_dq_i),
    .op_we_o   (op_we),
    .ce_n_o    (sram_ce_no),
    .we_n_o    (sram_we_no),
    .oe_n_o    (sram_oe_no),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .dq_oe_o   (sram_dq_oe_o),
    .rdata_o   (rdata_o)
  );

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned WR_C   = 2,
  parameter int unsigned RD_C   = 2,
  parameter int unsigned TA_C   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_dq_oe_o
);

  int unsigned we_run_q, oe_run_q, since_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q   <= 0;
      oe_run_q   <= 0;
      since_oe_q <= 32'hffff;
    end else begin
      we_run_q   <= sram_we_no ? 0 : we_run_q + 1;
      oe_run_q   <= sram_oe_no ? 0 : oe_run_q + 1;
      since_oe_q <= !sram_oe_no ? 0 : (since_oe_q == 32'hffff ? since_oe_q : since_oe_q + 1);
    end
  end

  a_r7_no_bus_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_oe_no));
  a_r7_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));
  a_r9_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> !ready_o);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_then_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  a_r10_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));
  a_r10_deselect_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sram_ce_no);
  a_r3_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_run_q == WR_C));
  a_r4_hold_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_ce_no));
  a_r5_oe_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> (oe_run_q == RD_C));
  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (since_oe_q >= TA_C));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .WR_C(WR_C), .RD_C(RD_C), .TA_C(TA_C)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;

  localparam int CLK_NS    = 4;  // matches the 4000 ps default
  localparam int SETUP_CYC = 1;
  localparam int WR_CYC    = 2;
  localparam int RD_CYC    = 2;
  localparam int HD_CYC    = 1;
  localparam int TA_CYC    = 2;
  localparam int WR_LAT    = SETUP_CYC + WR_CYC + HD_CYC + 1;
  localparam int RD_LAT    = SETUP_CYC + RD_CYC + TA_CYC + 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready_o, done_o, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata_o, dq_o, dq_i = 8'hee;
  logic [14:0] sram_addr;

  int n_chk = 0, n_bad = 0;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n), .sram_addr_o(sram_addr),
    .sram_dq_o(dq_o), .sram_dq_i(dq_i), .sram_dq_oe_o(dq_oe)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // RAM model: data valid only in the last cycle of the output window
  logic [7:0] mem [logic [14:0]];
  int oe_cnt = 0;
  always @(posedge clk) begin
    if (!ce_n && !we_n && dq_oe) mem[sram_addr] = dq_o;
    oe_cnt <= oe_n ? 0 : oe_cnt + 1;
  end
  always @(negedge clk) begin
    if (!ce_n && !oe_n && we_n && oe_cnt >= RD_CYC - 1)
      dq_i <= mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
    else
      dq_i <= 8'hee;
  end

  // scoreboard
  logic [7:0]  shadow [logic [14:0]];
  bit          exp_rd [$];
  logic [7:0]  exp_dat [$];
  logic [14:0] exp_adr [$];

  always @(negedge clk) if (rst_n && done_o) begin
    if (exp_rd.size() == 0) check(0, "R8", "done without request", 1, 0);
    else begin
      bit rd; logic [7:0] d; logic [14:0] a;
      rd = exp_rd.pop_front(); d = exp_dat.pop_front(); a = exp_adr.pop_front();
      if (rd) check(rdata_o == d, "R5", $sformatf("rdata @%0h", a), rdata_o, d);
      else    check(mem.exists(a) && mem[a] == d, "R3", $sformatf("ram @%0h", a),
                    mem.exists(a) ? mem[a] : 'hx, d);
    end
  end

  // pin monitor
  logic p_we_n = 1, p_oe_n = 1, p_ce_n = 1, p_dq_oe = 0, p_done = 0;
  logic [14:0] p_addr = '0;
  int we_run = 0, oe_run = 0, hold_run = 0, since_oe = 1000;
  bit in_hold = 0, addr_moved = 0;
  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !oe_n) check(0, "R7", "drive while output strobe low", 1, 0);
    if (!we_n && !oe_n) check(0, "R7", "both strobes low", 1, 0);
    if (ready_o) check(ce_n && we_n && oe_n && !dq_oe, "R2", "idle pins",
                       {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    if (done_o && p_done) check(0, "R8", "done wider than one cycle", 2, 1);
    if (done_o) check(ce_n, "R10", "deselect at done", ce_n, 1);
    if (!we_n) begin
      if (p_we_n) check(!ce_n && !p_ce_n, "R3", "chip select before strobe", p_ce_n, 0);
      check(dq_oe, "R3", "drive during strobe", dq_oe, 1);
      we_run++;
    end else if (!p_we_n) begin
      check(we_run == WR_CYC, "R3", "write strobe width", we_run, WR_CYC);
      check(dq_oe && sram_addr == p_addr, "R4", "hold after strobe", dq_oe, 1);
      we_run = 0; in_hold = 1; hold_run = 0;
    end
    if (in_hold) begin
      if (dq_oe) hold_run++;
      else begin check(hold_run == HD_CYC, "R4", "hold length", hold_run, HD_CYC); in_hold = 0; end
    end
    if (!oe_n) begin
      check(we_n, "R5", "write strobe high during read", we_n, 1);
      oe_run++;
    end else if (!p_oe_n) begin
      check(oe_run == RD_CYC, "R5", "output strobe width", oe_run, RD_CYC);
      oe_run = 0;
    end
    if (dq_oe && !p_dq_oe) check(since_oe >= TA_CYC, "R6", "turnaround", since_oe, TA_CYC);
    since_oe = oe_n ? since_oe + 1 : 0;
    if (!ce_n && !p_ce_n && sram_addr != p_addr) addr_moved = 1;
    if (ce_n && !p_ce_n) begin
      check(!addr_moved, "R10", "address stable under select", addr_moved, 0);
      addr_moved = 0;
    end
    p_we_n = we_n; p_oe_n = oe_n; p_ce_n = ce_n; p_dq_oe = dq_oe; p_addr = sram_addr; p_done = done_o;
  end

  task automatic push(bit wr, logic [14:0] a, logic [7:0] d);
    exp_rd.push_back(!wr);
    exp_adr.push_back(a);
    if (wr) begin shadow[a] = d; exp_dat.push_back(d); end
    else exp_dat.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
  endtask

  task automatic access(bit wr, logic [14:0] a, logic [7:0] d);
    int lat;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1; we = wr; addr = a; wdata = d;
    push(wr, a, d);
    @(negedge clk);
    req = 0; lat = 1;
    while (!done_o) begin @(negedge clk); lat++; end
    check(lat == (wr ? WR_LAT : RD_LAT), "R8", wr ? "write latency" : "read latency",
          lat, wr ? WR_LAT : RD_LAT);
  endtask

  // request held across a busy access with changing inputs
  task automatic busy_test(logic [14:0] a, logic [14:0] b, logic [7:0] d);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    push(1, a, d);
    @(negedge clk);
    we = 0; addr = b; wdata = ~d;
    while (!done_o) begin
      check(!ready_o, "R9", "ready while busy", ready_o, 0);
      if (!ce_n) check(sram_addr == a, "R9", "address follows accepted request", sram_addr, a);
      @(negedge clk);
    end
    req = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    check(0, "R8", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !done_o && ready_o, "R1", "pins in reset",
          {ce_n, we_n, oe_n, dq_oe, done_o, ready_o}, 6'b111001);
    rst_n = 1;
    @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !done_o && ready_o, "R1", "pins after reset",
          {ce_n, we_n, oe_n, dq_oe, done_o, ready_o}, 6'b111001);

    access(1, 15'h0000, 8'h00);
    access(1, 15'h7fff, 8'hff);
    access(1, 15'h2aaa, 8'h55);
    access(1, 15'h5555, 8'haa);
    access(0, 15'h0000, 8'h00);
    access(0, 15'h7fff, 8'h00);
    access(0, 15'h2aaa, 8'h00);
    access(0, 15'h5555, 8'h00);
    access(0, 15'h1234, 8'h00);  // never written

    // read followed at once by write (R6 window)
    for (int i = 0; i < 4; i++) begin
      access(0, 15'h7fff, 8'h00);
      access(1, 15'h7fff, 8'(8'h10 + i));
    end
    access(0, 15'h7fff, 8'h00);

    busy_test(15'h0100, 15'h0200, 8'h3c);
    access(0, 15'h0100, 8'h00);
    access(0, 15'h0200, 8'h00);

    // stream with request held high through idle
    lfsr = 16'hace1;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      bit wr;
      wr = (i < 12) || lfsr[0];
      req = 1; we = wr; addr = 15'(lfsr[15:1] & 15'h001f); wdata = lfsr[7:0];
      push(wr, addr, wdata);
      @(negedge clk);
      while (!ready_o) @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    req = 0;
    repeat (4) @(negedge clk);
    check(exp_rd.size() == 0, "R8", "one done per request", exp_rd.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule